// File: doc/BRIEF.md
# Programmable Per-Channel Threshold Trigger

The block watches a small group of sample streams and compares each incoming sample with a threshold held in a register owned by its channel. A channel hits when a valid sample is strictly greater than that channel's threshold. Any hit on a sample raises a one-cycle trigger pulse. Each channel also drives a hit line of its own, and these lines are spaced apart in time: the first channel lags the trigger by one step, the second by two steps, and so on. At the intended 20 MHz clock one step is one 50 ns cycle, so the four channels lag by 50, 100, 150 and 200 ns.

Software loads the thresholds over a plain register bus. The bus has an address, write data, a write enable and read data that follows the address in the same cycle, and every threshold can be read back. The thresholds come from pedestal and noise figures that the host works out. Every threshold resets to all ones, so nothing fires before software programs it.

Top module: `thresh_trigger`

## Requirements
- R1: While reset is asserted and right after it, every threshold reads back as all ones (0x3FF with 10-bit samples), and `trig_o` and every `chan_hit_o` bit are low.
- R2: A write with `reg_we_i` high to word address i (0 ≤ i < NUM_CH) stores `reg_wdata_i` as channel i's threshold. `reg_rdata_o` shows the threshold of the channel that `reg_addr_i` selects in the same cycle, with no register stage on the read path.
- R3: A read at an address of NUM_CH or above returns zero. A write to such an address leaves every threshold unchanged.
- R4: Channel i hits on a sample only when `sample_vld_i` is high and its sample, taken from `samples_i[i*SAMPLE_W +: SAMPLE_W]`, is strictly greater than its threshold. A sample equal to the threshold does not hit. Nothing hits while `sample_vld_i` is low.
- R5: `trig_o` is high for exactly the one cycle that follows the clock edge which captured a sample on which any channel hit, and it is low in every other cycle.
- R6: `chan_hit_o[i]` is high for exactly one cycle, and that cycle comes (i+1)·STEP cycles after the corresponding `trig_o` cycle.
- R7: A threshold written at one clock edge is applied to samples from the next clock edge on. A sample captured at the same edge as the write is compared with the old value.
- R8: A channel whose threshold is all ones never hits, whatever its sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (20 MHz in the target system) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_vld_i | input | 1 | All channel samples are valid this cycle |
| samples_i | input | NUM_CH*SAMPLE_W | Channel samples packed side by side, channel 0 in the low bits |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | SAMPLE_W | Threshold value to write |
| reg_we_i | input | 1 | Write strobe |
| reg_rdata_o | output | SAMPLE_W | Read data for `reg_addr_i` in the same cycle |
| chan_hit_o | output | NUM_CH | Per-channel hit lines, channel i delayed by (i+1)·STEP cycles |
| trig_o | output | 1 | One-cycle trigger pulse, OR of all channel hits |

## Verification
The bench builds the block with 4-bit samples, a 3-bit address and a one-cycle step, and keeps four channels. With that build every threshold value and every sample value can be swept against each other, and the all-ones threshold is one of the values the sweep covers. The full unmapped address range is also reachable, so each read at an unmapped address and each write to one can be tried. Because the step is one cycle, the bench can watch the whole trigger and hit-line window after every sample and confirm that no pulse appears outside its expected cycle.

// File: rtl/thresh_trigger_pkg.sv
package thresh_trigger_pkg;

   // Default configuration of the trigger block
   localparam int unsigned TT_NUM_CH   = 4;
   localparam int unsigned TT_SAMPLE_W = 10;
   localparam int unsigned TT_ADDR_W   = 4;
   localparam int unsigned TT_STEP     = 1;

   // Delay in cycles applied to a channel's hit line, relative to the trigger
   function automatic int unsigned tt_lag(input int unsigned ch, input int unsigned step);
      return (ch + 1) * step;
   endfunction

endpackage

// File: rtl/thresh_trigger_regs.sv
module thresh_trigger_regs #(
   parameter int unsigned NUM_CH   = thresh_trigger_pkg::TT_NUM_CH,
   parameter int unsigned SAMPLE_W = thresh_trigger_pkg::TT_SAMPLE_W,
   parameter int unsigned ADDR_W   = thresh_trigger_pkg::TT_ADDR_W
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic [SAMPLE_W-1:0]          wdata_i,
   input  logic                         we_i,
   output logic [SAMPLE_W-1:0]          rdata_o,
   output logic [NUM_CH*SAMPLE_W-1:0]   thr_o
);

   localparam logic [SAMPLE_W-1:0] THR_RESET = '1;

   logic [SAMPLE_W-1:0] thr_q [NUM_CH];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_thr
      logic sel;
      assign sel = we_i && (addr_i == ADDR_W'(g));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            thr_q[g] <= THR_RESET;
         end else if (sel) begin
            thr_q[g] <= wdata_i;
         end
      end

      assign thr_o[g*SAMPLE_W +: SAMPLE_W] = thr_q[g];
   end

   // Read path with no register stage; unmapped addresses give zero
   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr_i == ADDR_W'(i)) begin
            rdata_o = thr_q[i];
         end
      end
   end

endmodule

// File: rtl/thresh_trigger_cmp.sv
module thresh_trigger_cmp #(
   parameter int unsigned SAMPLE_W = thresh_trigger_pkg::TT_SAMPLE_W
) (
   input  logic                vld_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic [SAMPLE_W-1:0] thr_i,
   output logic                hit_o
);

   assign hit_o = vld_i && (sample_i > thr_i);

endmodule

// File: rtl/thresh_trigger_dly.sv
module thresh_trigger_dly #(
   parameter int unsigned DEPTH = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("thresh_trigger_dly: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) q <= 1'b0;
         else         q <= d_i;
      end
      assign q_o = q;
   end else begin : g_chain
      logic [DEPTH-1:0] sr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) sr_q <= '0;
         else         sr_q <= {sr_q[DEPTH-2:0], d_i};
      end
      assign q_o = sr_q[DEPTH-1];
   end

endmodule

// File: rtl/thresh_trigger.sv
module thresh_trigger #(
   parameter int unsigned NUM_CH   = thresh_trigger_pkg::TT_NUM_CH,
   parameter int unsigned SAMPLE_W = thresh_trigger_pkg::TT_SAMPLE_W,
   parameter int unsigned ADDR_W   = thresh_trigger_pkg::TT_ADDR_W,
   parameter int unsigned STEP     = thresh_trigger_pkg::TT_STEP
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         sample_vld_i,
   input  logic [NUM_CH*SAMPLE_W-1:0]   samples_i,
   input  logic [ADDR_W-1:0]            reg_addr_i,
   input  logic [SAMPLE_W-1:0]          reg_wdata_i,
   input  logic                         reg_we_i,
   output logic [SAMPLE_W-1:0]          reg_rdata_o,
   output logic [NUM_CH-1:0]            chan_hit_o,
   output logic                         trig_o
);

   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("thresh_trigger: NUM_CH must be at least 1");
   end
   if (ADDR_SPAN < NUM_CH) begin : g_bad_addr
      $error("thresh_trigger: ADDR_W too narrow for NUM_CH registers");
   end
   if (SAMPLE_W < 1) begin : g_bad_w
      $error("thresh_trigger: SAMPLE_W must be at least 1");
   end
   if (STEP < 1) begin : g_bad_step
      $error("thresh_trigger: STEP must be at least 1");
   end

   logic [NUM_CH*SAMPLE_W-1:0] thr_flat;
   logic [NUM_CH-1:0]          hit_raw;
   logic [NUM_CH-1:0]          hit_q;
   logic                       trig_q;

   thresh_trigger_regs #(
      .NUM_CH   (NUM_CH),
      .SAMPLE_W (SAMPLE_W),
      .ADDR_W   (ADDR_W)
   ) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .addr_i  (reg_addr_i),
      .wdata_i (reg_wdata_i),
      .we_i    (reg_we_i),
      .rdata_o (reg_rdata_o),
      .thr_o   (thr_flat)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      thresh_trigger_cmp #(
         .SAMPLE_W (SAMPLE_W)
      ) u_cmp (
         .vld_i    (sample_vld_i),
         .sample_i (samples_i[g*SAMPLE_W +: SAMPLE_W]),
         .thr_i    (thr_flat[g*SAMPLE_W +: SAMPLE_W]),
         .hit_o    (hit_raw[g])
      );

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) hit_q[g] <= 1'b0;
         else         hit_q[g] <= hit_raw[g];
      end

      thresh_trigger_dly #(
         .DEPTH (thresh_trigger_pkg::tt_lag(g, STEP))
      ) u_dly (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .d_i    (hit_q[g]),
         .q_o    (chan_hit_o[g])
      );
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) trig_q <= 1'b0;
      else         trig_q <= |hit_raw;
   end

   assign trig_o = trig_q;

endmodule

// File: rtl/thresh_trigger_chk.sv
module thresh_trigger_chk #(
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned SAMPLE_W = 10,
   parameter int unsigned ADDR_W   = 4
) (
   input logic                       clk_i,
   input logic                       rst_ni,
   input logic                       sample_vld_i,
   input logic [ADDR_W-1:0]          reg_addr_i,
   input logic [SAMPLE_W-1:0]        reg_wdata_i,
   input logic                       reg_we_i,
   input logic [SAMPLE_W-1:0]        reg_rdata_o,
   input logic                       trig_o,
   input logic [NUM_CH*SAMPLE_W-1:0] thr_flat,
   input logic [NUM_CH-1:0]          hit_raw
);

   logic mapped;
   assign mapped = int'(reg_addr_i) < NUM_CH;

   // R3
   unmapped_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mapped |-> reg_rdata_o == '0);

   // R2
   write_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(reg_we_i && mapped) && reg_addr_i == $past(reg_addr_i))
      |-> reg_rdata_o == $past(reg_wdata_i));

   // R3
   hold_without_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(reg_we_i && mapped) && reg_addr_i == $past(reg_addr_i))
      |-> $stable(reg_rdata_o));

   // R5
   trig_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_o |-> $past(sample_vld_i));

   // R4
   no_hit_without_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sample_vld_i |-> hit_raw == '0);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      // R8
      max_thr_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (thr_flat[g*SAMPLE_W +: SAMPLE_W] == {SAMPLE_W{1'b1}}) |-> !hit_raw[g]);
   end

endmodule

bind thresh_trigger thresh_trigger_chk #(
   .NUM_CH   (NUM_CH),
   .SAMPLE_W (SAMPLE_W),
   .ADDR_W   (ADDR_W)
) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .sample_vld_i (sample_vld_i),
   .reg_addr_i   (reg_addr_i),
   .reg_wdata_i  (reg_wdata_i),
   .reg_we_i     (reg_we_i),
   .reg_rdata_o  (reg_rdata_o),
   .trig_o       (trig_o),
   .thr_flat     (thr_flat),
   .hit_raw      (hit_raw)
);

// File: tb/thresh_trigger_tb_top.sv
module thresh_trigger_tb_top;

   localparam int NCH = 4;
   localparam int SW  = 4;
   localparam int AW  = 3;
   localparam int MAXV = (1 << SW) - 1;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               vld = 1'b0;
   logic [NCH*SW-1:0]  smp = '0;
   logic [AW-1:0]      addr = '0;
   logic [SW-1:0]      wdata = '0;
   logic               we = 1'b0;
   logic [SW-1:0]      rdata;
   logic [NCH-1:0]     chan_hit;
   logic               trig;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2 clk = ~clk;

   thresh_trigger #(
      .NUM_CH   (NCH),
      .SAMPLE_W (SW),
      .ADDR_W   (AW),
      .STEP     (1)
   ) dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .sample_vld_i (vld),
      .samples_i    (smp),
      .reg_addr_i   (addr),
      .reg_wdata_i  (wdata),
      .reg_we_i     (we),
      .reg_rdata_o  (rdata),
      .chan_hit_o   (chan_hit),
      .trig_o       (trig)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      addr = AW'(a); wdata = SW'(d); we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int a, input int exp);
      @(negedge clk);
      addr = AW'(a);
      #1;
      chk(req, 32'(rdata), 32'(exp));
   endtask

   // Drive one valid sample set, then watch the output window (R5, R6)
   task automatic trial(input string req, input int t, input logic [NCH*SW-1:0] s, input logic v);
      logic [NCH-1:0] e;
      for (int i = 0; i < NCH; i++) e[i] = v && (int'(s[i*SW +: SW]) > t);
      @(negedge clk);
      vld = v; smp = s;
      for (int c = 1; c <= NCH + 2; c++) begin
         logic [NCH:0] expv;
         @(negedge clk);
         vld = 1'b0;
         #1;
         expv[0] = (c == 1) && (|e);
         for (int i = 0; i < NCH; i++) expv[i+1] = (c == i + 2) && e[i];
         chk(req, 32'({chan_hit, trig}), 32'(expv));
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      #1;
      chk("R1 trig in reset", 32'(trig), 0);
      chk("R1 chan in reset", 32'(chan_hit), 0);
      rst_n = 1'b1;
      for (int a = 0; a < NCH; a++) rd_chk("R1 reset threshold", a, MAXV);
      // R8: all-ones thresholds after reset never hit
      trial("R8 reset thresholds", MAXV, '1, 1'b1);

      // R3: unmapped reads zero, writes ignored
      for (int a = NCH; a < (1 << AW); a++) begin
         wr(a, 0);
         rd_chk("R3 unmapped read", a, 0);
      end
      for (int a = 0; a < NCH; a++) rd_chk("R3 unmapped write ignored", a, MAXV);

      // R7: write and sample on the same edge use the old threshold
      @(negedge clk);
      addr = '0; wdata = SW'(3); we = 1'b1; vld = 1'b1; smp = '0;
      smp[SW-1:0] = SW'(8);
      @(negedge clk);
      we = 1'b0; vld = 1'b1;
      #1;
      chk("R7 old threshold applies", 32'(trig), 0);
      @(negedge clk);
      vld = 1'b0;
      #1;
      chk("R7 new threshold applies", 32'(trig), 1);
      repeat (NCH + 2) @(negedge clk);

      // R4 (valid low): nothing hits
      wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 0);
      trial("R4 valid low", 0, '1, 1'b0);

      // R2, R4, R5, R6, R8: full sweep of thresholds against samples
      for (int t = 0; t <= MAXV; t++) begin
         for (int a = 0; a < NCH; a++) wr(a, t);
         for (int a = 0; a < NCH; a++) rd_chk("R2 readback", a, t);
         for (int s = 0; s <= MAXV; s++) begin
            logic [NCH*SW-1:0] sv;
            for (int i = 0; i < NCH; i++) sv[i*SW +: SW] = SW'((s + i * 5) % (MAXV + 1));
            trial("R4 R5 R6 sweep", t, sv, 1'b1);
         end
      end

      // R2: distinct values per channel
      for (int a = 0; a < NCH; a++) wr(a, a * 3 + 1);
      for (int a = 0; a < NCH; a++) rd_chk("R2 distinct readback", a, a * 3 + 1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule